// File: doc/BRIEF.md
# Token-Ring Dual-Clock Synchronizing FIFO

This block carries data words from a write clock domain to an unrelated read clock domain. It is a ring of `STAGES` identical slots. Each slot has one data register and one occupancy flag. A one-hot write token selects the slot for the next write, and a one-hot read token selects the slot for the next read. Each token moves one slot forward after every transfer on its own side and wraps from the last slot back to slot 0.

The occupancy flag of each slot is split into two toggle bits. The write side flips the first bit when it fills the slot. The read side flips the second bit when it empties the slot. The slot is full when the two bits differ. Each side receives the other side's toggle bits through its own chain of one-bit synchronizers, with one chain per slot. The chain depth is set separately for each side, so a fast domain can use a deeper chain than a slow one.

The producer raises `wr_req` with `wr_data` and the word is taken on any write edge where `wr_ready` is high. The consumer sees `rd_valid` with `rd_data` and takes the word by raising `rd_take`.

Top module: `ring_sync_fifo`

## Requirements
- R1: After reset, `wr_ready` is 1 and `rd_valid` is 0, and both keep those values while no word is written.
- R2: Every accepted word comes out exactly once on `rd_data`, in the order it was accepted, including after the tokens wrap from slot STAGES-1 back to slot 0. Exactly one slot holds the write token and exactly one slot holds the read token at all times.
- R3: With no reads, exactly STAGES words are accepted, and `wr_ready` is then 0.
- R4: `wr_req` raised while `wr_ready` is 0 stores nothing and does not move the write token.
- R5: `rd_take` raised while `rd_valid` is 0 removes nothing and does not move the read token.
- R6: While `rd_valid` is 1 and `rd_take` is 0, `rd_valid` stays 1 and `rd_data` is held.
- R7: `wr_ready` can fall only on a write edge that accepts a word. `rd_valid` can fall only on a read edge that takes a word.
- R8: A word written into an empty FIFO raises `rd_valid` after exactly RD_SYNC read-clock rising edges that follow the write edge. This delay does not depend on STAGES.
- R9: When the FIFO is full, a read makes `wr_ready` rise after exactly WR_SYNC write-clock rising edges that follow the read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst_n | input | 1 | Write domain reset, asynchronous, active low |
| wr_req | input | 1 | Producer offers `wr_data` |
| wr_data | input | WIDTH | Word to store |
| wr_ready | output | 1 | The slot holding the write token is seen as empty |
| rd_clk | input | 1 | Read domain clock |
| rd_rst_n | input | 1 | Read domain reset, asynchronous, active low |
| rd_take | input | 1 | Consumer takes the presented word |
| rd_valid | output | 1 | The slot holding the read token is seen as full |
| rd_data | output | WIDTH | Word in the slot holding the read token |

## Verification
The assertions check on every cycle that both tokens stay one-hot. They check that a refused write or an idle read leaves the toggle bits unchanged, that a presented word stays put until it is taken, and that neither flag falls without a transfer on its own side. Ordering under random stalls on both sides with unrelated clock periods can only be shown by the bench's scenarios. The same holds for the exact capacity, the wrap of the tokens, and the synchronizer-determined delays in each direction.

// File: rtl/ring_sync_fifo.sv
module ring_sync_fifo #(
  parameter int WIDTH   = 8,
  parameter int STAGES  = 4,
  parameter int WR_SYNC = 2,
  parameter int RD_SYNC = 2
) (
  input  logic             wr_clk,
  input  logic             wr_rst_n,
  input  logic             wr_req,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_ready,
  input  logic             rd_clk,
  input  logic             rd_rst_n,
  input  logic             rd_take,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data
);

  logic [STAGES-1:0] wtok, wflip, rtok, rflip;
  logic [STAGES-1:0] rflip_seen [WR_SYNC];
  logic [STAGES-1:0] wflip_seen [RD_SYNC];
  logic [WIDTH-1:0]  slot [STAGES];
  logic [STAGES-1:0] full_w, full_r;
  logic              wr_fire, rd_fire;

  assign full_w   = wflip ^ rflip_seen[WR_SYNC-1];
  assign full_r   = wflip_seen[RD_SYNC-1] ^ rflip;
  assign wr_ready = ~|(wtok & full_w);
  assign rd_valid = |(rtok & full_r);
  assign wr_fire  = wr_req & wr_ready;
  assign rd_fire  = rd_take & rd_valid;

  always_ff @(posedge wr_clk or negedge wr_rst_n)
    if (!wr_rst_n) begin
      wtok  <= STAGES'(1);
      wflip <= '0;
    end else if (wr_fire) begin
      wtok  <= {wtok[STAGES-2:0], wtok[STAGES-1]};
      wflip <= wflip ^ wtok;
    end

  always_ff @(posedge rd_clk or negedge rd_rst_n)
    if (!rd_rst_n) begin
      rtok  <= STAGES'(1);
      rflip <= '0;
    end else if (rd_fire) begin
      rtok  <= {rtok[STAGES-2:0], rtok[STAGES-1]};
      rflip <= rflip ^ rtok;
    end

  for (genvar i = 0; i < STAGES; i++) begin : g_slot
    always_ff @(posedge wr_clk or negedge wr_rst_n)
      if (!wr_rst_n)               slot[i] <= '0;
      else if (wr_fire && wtok[i]) slot[i] <= wr_data;
  end

  for (genvar k = 0; k < WR_SYNC; k++) begin : g_wsync
    always_ff @(posedge wr_clk or negedge wr_rst_n)
      if (!wr_rst_n)   rflip_seen[k] <= '0;
      else if (k == 0) rflip_seen[k] <= rflip;
      else             rflip_seen[k] <= rflip_seen[(k > 0) ? k-1 : 0];
  end

  for (genvar k = 0; k < RD_SYNC; k++) begin : g_rsync
    always_ff @(posedge rd_clk or negedge rd_rst_n)
      if (!rd_rst_n)   wflip_seen[k] <= '0;
      else if (k == 0) wflip_seen[k] <= wflip;
      else             wflip_seen[k] <= wflip_seen[(k > 0) ? k-1 : 0];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < STAGES; i++)
      if (rtok[i]) rd_data = rd_data | slot[i];
  end

endmodule

// File: rtl/ring_sync_fifo_chk.sv
module ring_sync_fifo_chk #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 4
) (
  input logic              wr_clk,
  input logic              wr_rst_n,
  input logic              wr_req,
  input logic              wr_ready,
  input logic [STAGES-1:0] wtok,
  input logic [STAGES-1:0] wflip,
  input logic              rd_clk,
  input logic              rd_rst_n,
  input logic              rd_take,
  input logic              rd_valid,
  input logic [WIDTH-1:0]  rd_data,
  input logic [STAGES-1:0] rtok,
  input logic [STAGES-1:0] rflip
);

  p_wtok_onehot_r2: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wtok) == 1);

  p_rtok_onehot_r2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rtok) == 1);

  p_refused_write_r4: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_req && !wr_ready) |=> ($stable(wflip) && $stable(wtok)));

  p_idle_read_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_take && !rd_valid) |=> ($stable(rflip) && $stable(rtok)));

  p_hold_word_r6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_valid && !rd_take) |=> (rd_valid && $stable(rd_data)));

  p_ready_keeps_r7: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_ready && !wr_req) |=> wr_ready);

endmodule

bind ring_sync_fifo ring_sync_fifo_chk #(.WIDTH(WIDTH), .STAGES(STAGES)) u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_req(wr_req), .wr_ready(wr_ready),
  .wtok(wtok), .wflip(wflip),
  .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_take(rd_take), .rd_valid(rd_valid),
  .rd_data(rd_data), .rtok(rtok), .rflip(rflip)
);

// File: tb/test_ring_sync_fifo.sv
module test_ring_sync_fifo;
  localparam int WIDTH = 8, STAGES = 4, WR_SYNC = 2, RD_SYNC = 2;
  localparam int WR_PERIOD = 10;
  localparam int RD_PERIOD = 14;
  localparam int NROW = 4;
  // each row: {word count, write stall percent, read stall percent}
  localparam logic [NROW-1:0][23:0] ROWS = {24'd60_30_30 & 24'h0, 24'h3C1E1E, 24'h280A3C, 24'h28320A} | 24'h14_00_00;

  logic wr_clk = 0, rd_clk = 0, wr_rst_n = 0, rd_rst_n = 0;
  logic wr_req = 0, rd_take = 0, wr_ready, rd_valid;
  logic [WIDTH-1:0] wr_data = '0, rd_data;
  int compared = 0, mismatched = 0;
  bit finished = 0;

  ring_sync_fifo #(.WIDTH(WIDTH), .STAGES(STAGES), .WR_SYNC(WR_SYNC), .RD_SYNC(RD_SYNC))
    i_ring_sync_fifo (.*);

  initial forever #(WR_PERIOD/2) wr_clk = ~wr_clk;
  initial begin #1; forever #(RD_PERIOD/2) rd_clk = ~rd_clk; end

  function automatic logic [WIDTH-1:0] word(int key, int idx);
    return WIDTH'(key * 61 + idx * 13 + 1);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_row(int words, int wstall, int rstall, int key);
    fork
      begin
        int sent = 0;
        while (sent < words) begin
          @(negedge wr_clk);
          if (int'($urandom_range(99)) < wstall) wr_req = 0;
          else begin
            wr_req = 1;
            if (wr_ready) begin wr_data = word(key, sent); sent++; end
            else wr_data = ~word(key, sent); // R4: refused word must never appear
          end
        end
        @(negedge wr_clk) wr_req = 0;
      end
      begin
        int got = 0;
        while (got < words) begin
          @(negedge rd_clk);
          if (rd_valid) chk(rd_data == word(key, got), "R2", rd_data, word(key, got));
          // R5: take is also raised while nothing is valid
          rd_take = (int'($urandom_range(99)) >= rstall);
          if (rd_take && rd_valid) got++;
        end
        @(negedge rd_clk) rd_take = 0;
      end
    join
    repeat (10) @(negedge wr_clk);
  endtask

  initial begin
    #(WR_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int acc, n, got;
    #31 wr_rst_n = 1; rd_rst_n = 1;
    @(negedge wr_clk);
    chk(wr_ready == 1, "R1", wr_ready, 1);
    chk(rd_valid == 0, "R1", rd_valid, 0);
    repeat (20) @(negedge rd_clk);
    chk(wr_ready == 1, "R1 R7", wr_ready, 1);
    chk(rd_valid == 0, "R1", rd_valid, 0);

    for (int r = 0; r < NROW; r++)
      run_row(int'(ROWS[r][23:16]), int'(ROWS[r][15:8]), int'(ROWS[r][7:0]), r + 3);

    // R3: capacity with no reads
    acc = 0;
    repeat (3 * STAGES) begin
      @(negedge wr_clk);
      wr_req = 1;
      if (wr_ready) begin wr_data = word(9, acc); acc++; end
      else wr_data = 8'hA5;
    end
    @(negedge wr_clk) wr_req = 0;
    chk(acc == STAGES, "R3", acc, STAGES);
    chk(wr_ready == 0, "R3", wr_ready, 0);

    // R6: word held while not taken
    @(negedge rd_clk);
    chk(rd_valid && rd_data == word(9, 0), "R6", rd_data, word(9, 0));
    repeat (3) @(negedge rd_clk);
    chk(rd_valid && rd_data == word(9, 0), "R6", rd_data, word(9, 0));

    // R9: write side sees the freed slot after WR_SYNC write edges
    rd_take = 1;
    @(posedge rd_clk);
    fork begin @(negedge rd_clk) rd_take = 0; end join_none
    n = 0;
    while (n < 10) begin
      @(posedge wr_clk); n++;
      @(negedge wr_clk);
      if (wr_ready) break;
    end
    chk(n == WR_SYNC, "R9", n, WR_SYNC);

    // R2: one more word wraps the write token to slot 0
    wr_req = 1; wr_data = word(9, 4);
    @(negedge wr_clk) wr_req = 0;
    got = 1;
    while (got < 5) begin
      @(negedge rd_clk);
      if (rd_valid) begin
        chk(rd_data == word(9, got), "R2", rd_data, word(9, got));
        rd_take = 1; got++;
      end else rd_take = 0;
    end
    @(negedge rd_clk) rd_take = 0;
    chk(rd_valid == 0, "R2", rd_valid, 0);
    repeat (10) @(negedge wr_clk);

    // R5: take while empty
    @(negedge rd_clk) rd_take = 1;
    repeat (5) @(negedge rd_clk);
    chk(rd_valid == 0, "R5", rd_valid, 0);
    rd_take = 0;

    // R8: read-side delay from the write edge
    @(negedge wr_clk);
    wr_req = 1; wr_data = word(11, 0);
    @(posedge wr_clk);
    fork begin @(negedge wr_clk) wr_req = 0; end join_none
    n = 0;
    while (n < 10) begin
      @(posedge rd_clk); n++;
      @(negedge rd_clk);
      if (rd_valid) break;
    end
    chk(n == RD_SYNC, "R8", n, RD_SYNC);
    chk(rd_data == word(11, 0), "R5 R8", rd_data, word(11, 0));
    rd_take = 1;
    @(negedge rd_clk) rd_take = 0;
    chk(rd_valid == 0, "R2", rd_valid, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule